// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small 8-bit processor core, together with the status register it updates. The result path is combinational: from two operands, an operation code and the current carry, it produces an 8-bit result and a write-back enable within the same cycle. The status register is a bank of eight flag flops. On each clock edge where `issue` is high, it takes the flags the selected operation defines and leaves every other flag unchanged.

The operation set covers:
- binary add and subtract, each with a variant that chains through the carry, and compare in the same two forms;
- bitwise AND, OR and XOR;
- one's and two's complement, increment and decrement;
- logical and arithmetic shifts, rotates through the carry, and nibble swap;
- setting or clearing any one status bit by its index.

Compare with carry and subtract with carry keep the zero flag sticky-low. Comparing a multi-byte value one byte at a time therefore ends with a correct zero flag. The register file, instruction decoding and multiplication are handled elsewhere.

Top module: `alu8_flags_unit`

## Requirements
- R1: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Synchronous reset clears all eight bits. The register changes only on a rising edge with `issue` high.
- R2: ADD gives opa+opb and ADC gives opa+opb+C. Both update C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), Z and N.
- R3: SUB gives opa-opb and SBC gives opa-opb-C. Both set C on a borrow out of bit 7, set H on a borrow out of bit 3, and update V and N.
- R4: SUB and CMP set Z when the difference is zero. SBC and CPC clear Z when the difference is non-zero and otherwise keep the previous Z.
- R5: CMP and CPC update flags exactly as SUB and SBC do, with `result_we` low.
- R6: AND, OR and XOR update Z and N, force V to 0, and leave C, H, T and I unchanged.
- R7: INC and DEC update Z, N and V, and leave C and H unchanged. V is set when INC takes 0x7F to 0x80 and when DEC takes 0x80 to 0x7F.
- R8: COM gives 0xFF-opa and sets C=1 and V=0, with H unchanged. NEG gives 0x00-opa and sets C when the result is non-zero, V when the result is 0x80, and H on a borrow out of bit 3.
- R9: Shift rules:
  - LSL shifts left with bit 7 moving to C.
  - LSR shifts right with 0 entering bit 7.
  - ASR shifts right keeping bit 7.
  - LSR and ASR move bit 0 to C.
  - All three set V=N^C, update Z and N, and leave H unchanged.
- R10: ROL takes the old C into bit 0 and moves bit 7 to C. ROR takes the old C into bit 7 and moves bit 0 to C. Both update Z, N, V and S as in R9.
- R11: SWAP exchanges bits 7..4 with bits 3..0, writes the result, and leaves every flag unchanged.
- R12: FSET sets and FCLR clears only the status bit at index `flag_sel`. T and I change only through these two operations.
- R13: Every operation that updates V leaves S equal to N XOR V.
- R14: Opcode values are:
  - ADD 0, ADC 1, SUB 2, SBC 3, CMP 4, CPC 5;
  - AND 6, OR 7, XOR 8, COM 9, NEG 10, INC 11, DEC 12;
  - LSL 13, LSR 14, ROL 15, ROR 16, ASR 17, SWAP 18;
  - FSET 19, FCLR 20.

  Codes 21 to 31 change no flag, drive `result_we` low and pass opa to `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is executed this cycle; status register loads at the edge |
| opcode | input | 5 | Operation code (see R14) |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (source register or constant) |
| flag_sel | input | 3 | Status bit index for FSET/FCLR |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| sreg | output | 8 | Registered status flags |

## Verification
Directed vectors target the values where the flag rules diverge:
- nibble and byte carry boundaries (0x0F+0x01, 0x80+0x80) separate H from C;
- 0x7F/0x80 crossings separate signed overflow from carry;
- a zero and non-zero two-byte compare chain shows whether Z is sticky;
- rotates run with both carry values to show that C is taken in.

Long random streams over all 32 opcode values, with idle cycles mixed in, follow. They catch any flag written outside its operation's subset, because the reference model carries every untouched bit forward from earlier operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int SR_W     = 8;
    localparam int SR_IDX_W = $clog2(SR_W);
    localparam int OP_W     = 5;

    // status bit positions (selected by index in FSET/FCLR)
    localparam int SR_C = 0;
    localparam int SR_Z = 1;
    localparam int SR_N = 2;
    localparam int SR_V = 3;
    localparam int SR_S = 4;
    localparam int SR_H = 5;
    localparam int SR_T = 6;
    localparam int SR_I = 7;

    localparam logic [SR_W-1:0] MASK_ZNVS  = SR_W'((1 << SR_Z) | (1 << SR_N) | (1 << SR_V) | (1 << SR_S));
    localparam logic [SR_W-1:0] MASK_ZCNVS = MASK_ZNVS | SR_W'(1 << SR_C);
    localparam logic [SR_W-1:0] MASK_FULL  = MASK_ZCNVS | SR_W'(1 << SR_H);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_FSET = 5'd19,
        OP_FCLR = 5'd20
    } alu_op_e;

    typedef struct packed {
        logic [SR_W-1:0] val;
        logic [SR_W-1:0] mask;
    } sr_upd_t;

    // assemble arithmetic flag values, sign derived from N and V
    function automatic logic [SR_W-1:0] sr_pack(input logic c, input logic z,
                                                input logic n, input logic v,
                                                input logic h);
        logic [SR_W-1:0] f;
        f       = '0;
        f[SR_C] = c;
        f[SR_Z] = z;
        f[SR_N] = n;
        f[SR_V] = v;
        f[SR_S] = n ^ v;
        f[SR_H] = h;
        return f;
    endfunction

    function automatic logic [SR_W-1:0] sr_onehot(input logic [SR_IDX_W-1:0] idx);
        logic [SR_W-1:0] f;
        f      = '0;
        f[idx] = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    input  logic              z_in,
    output logic              hit,
    output logic              is_cmp,
    output logic [DATA_W-1:0] res,
    output sr_upd_t           upd
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W-1:0] x, y;
    logic              cin, sub, chain, narrow;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   half;
    logic              ovf, zero;

    always_comb begin
        hit    = 1'b1;
        is_cmp = 1'b0;
        x      = a;
        y      = b;
        cin    = 1'b0;
        sub    = 1'b0;
        chain  = 1'b0;
        narrow = 1'b0;
        case (op)
            OP_ADD: ;
            OP_ADC: cin = c_in;
            OP_SUB: sub = 1'b1;
            OP_SBC: begin sub = 1'b1; cin = c_in; chain = 1'b1; end
            OP_CMP: begin sub = 1'b1; is_cmp = 1'b1; end
            OP_CPC: begin sub = 1'b1; cin = c_in; chain = 1'b1; is_cmp = 1'b1; end
            OP_NEG: begin sub = 1'b1; x = '0; y = a; end
            OP_INC: begin y = DATA_W'(1); narrow = 1'b1; end
            OP_DEC: begin sub = 1'b1; y = DATA_W'(1); narrow = 1'b1; end
            default: hit = 1'b0;
        endcase
    end

    // bit DATA_W / HALF_W is the carry or the borrow out
    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
            half = {1'b0, x[HALF_W-1:0]} - {1'b0, y[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
            half = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        end
    end

    assign res = full[DATA_W-1:0];

    always_comb begin
        if (sub)
            ovf = (x[MSB] != y[MSB]) && (res[MSB] != x[MSB]);
        else
            ovf = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
        zero = (res == '0);
        if (chain)
            zero = zero & z_in;
    end

    always_comb begin
        upd.val  = sr_pack(full[DATA_W], zero, res[MSB], ovf, half[HALF_W]);
        upd.mask = hit ? (narrow ? MASK_ZNVS : MASK_FULL) : '0;
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    output logic              hit,
    output logic [DATA_W-1:0] res,
    output sr_upd_t           upd
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic            c_out, shifting;
    logic [SR_W-1:0] mask;
    logic            ovf;

    always_comb begin
        hit      = 1'b1;
        res      = a;
        c_out    = c_in;
        shifting = 1'b0;
        mask     = MASK_ZNVS;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  begin res = ~a; c_out = 1'b1; mask = MASK_ZCNVS; end
            OP_LSL:  begin res = {a[MSB-1:0], 1'b0};  c_out = a[MSB]; shifting = 1'b1; mask = MASK_ZCNVS; end
            OP_LSR:  begin res = {1'b0, a[MSB:1]};    c_out = a[0];   shifting = 1'b1; mask = MASK_ZCNVS; end
            OP_ROL:  begin res = {a[MSB-1:0], c_in};  c_out = a[MSB]; shifting = 1'b1; mask = MASK_ZCNVS; end
            OP_ROR:  begin res = {c_in, a[MSB:1]};    c_out = a[0];   shifting = 1'b1; mask = MASK_ZCNVS; end
            OP_ASR:  begin res = {a[MSB], a[MSB:1]};  c_out = a[0];   shifting = 1'b1; mask = MASK_ZCNVS; end
            OP_SWAP: begin res = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]}; mask = '0; end
            default: begin hit = 1'b0; mask = '0; end
        endcase
    end

    assign ovf = shifting ? (res[MSB] ^ c_out) : 1'b0;

    always_comb begin
        upd.val  = sr_pack(c_out, res == '0, res[MSB], ovf, 1'b0);
        upd.mask = mask;
    end

endmodule

// File: rtl/alu8_sreg.sv
module alu8_sreg
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  sr_upd_t         upd,
    output logic [SR_W-1:0] q
);
    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (load && upd.mask[i])
                bit_q <= upd.val[i];
        end
        assign q[i] = bit_q;
    end

endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [OP_W-1:0]     opcode,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic [SR_IDX_W-1:0] flag_sel,
    output logic [DATA_W-1:0]   result,
    output logic                result_we,
    output logic [SR_W-1:0]     sreg
);
    alu_op_e           op;
    logic              as_hit, as_cmp, bo_hit;
    logic [DATA_W-1:0] as_res, bo_res;
    sr_upd_t           as_upd, bo_upd, fl_upd, sel_upd;

    assign op = alu_op_e'(opcode);

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op(op), .a(opa), .b(opb), .c_in(sreg[SR_C]), .z_in(sreg[SR_Z]),
        .hit(as_hit), .is_cmp(as_cmp), .res(as_res), .upd(as_upd)
    );

    alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op(op), .a(opa), .b(opb), .c_in(sreg[SR_C]),
        .hit(bo_hit), .res(bo_res), .upd(bo_upd)
    );

    // explicit single-bit set / clear
    always_comb begin
        fl_upd.mask = '0;
        fl_upd.val  = '0;
        if (op == OP_FSET) begin
            fl_upd.mask = sr_onehot(flag_sel);
            fl_upd.val  = '1;
        end else if (op == OP_FCLR) begin
            fl_upd.mask = sr_onehot(flag_sel);
        end
    end

    always_comb begin
        if (as_hit) begin
            sel_upd = as_upd;
            result  = as_res;
        end else if (bo_hit) begin
            sel_upd = bo_upd;
            result  = bo_res;
        end else begin
            sel_upd = fl_upd;
            result  = opa;
        end
    end

    assign result_we = (as_hit && !as_cmp) || bo_hit;

    alu8_sreg u_sreg (
        .clk(clk), .rst(rst), .load(issue), .upd(sel_upd), .q(sreg)
    );

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                issue,
    input logic [OP_W-1:0]     opcode,
    input logic [SR_IDX_W-1:0] flag_sel,
    input logic                result_we,
    input logic [SR_W-1:0]     sreg
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(sreg)); // R1

    AST_CHAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        issue && (opcode == OP_SBC || opcode == OP_CPC) && !sreg[SR_Z] |=> !sreg[SR_Z]); // R4

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        issue && (opcode == OP_CMP || opcode == OP_CPC) |-> !result_we); // R5

    AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (rst)
        issue && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
        |=> sreg[SR_C] == $past(sreg[SR_C]) && sreg[SR_H] == $past(sreg[SR_H]) && !sreg[SR_V]); // R6

    AST_INCDEC_KEEPS_CH: assert property (@(posedge clk) disable iff (rst)
        issue && (opcode == OP_INC || opcode == OP_DEC)
        |=> sreg[SR_C] == $past(sreg[SR_C]) && sreg[SR_H] == $past(sreg[SR_H])); // R7

    AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
        issue && opcode == OP_SWAP |=> $stable(sreg)); // R11

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        issue && (opcode == OP_FSET || opcode == OP_FCLR)
        |=> $countones(sreg ^ $past(sreg)) <= 1); // R12

    AST_FSET_TARGET: assert property (@(posedge clk) disable iff (rst)
        issue && opcode == OP_FSET |=> sreg[$past(flag_sel)]); // R12

    AST_TI_GUARDED: assert property (@(posedge clk) disable iff (rst)
        issue && opcode <= OP_SWAP |=> $stable(sreg[SR_I:SR_T])); // R12

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
        issue && opcode <= OP_ASR |=> sreg[SR_S] == (sreg[SR_N] ^ sreg[SR_V])); // R13

    AST_UNUSED_OP: assert property (@(posedge clk) disable iff (rst)
        issue && opcode > OP_FCLR |=> $stable(sreg)); // R14

endmodule

bind alu8_flags_unit alu8_flags_chk u_chk (
    .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
    .flag_sel(flag_sel), .result_we(result_we), .sreg(sreg)
);

// File: tb/tb_alu8_flags_unit.sv
`timescale 1ns/1ps
module tb_alu8_flags_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       issue;
    logic [4:0] opcode;
    logic [7:0] opa, opb;
    logic [2:0] flag_sel;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] sreg;

    int checks = 0;
    int failures = 0;
    logic [7:0] mf; // model status

    always #2 clk = ~clk; // 250 MHz

    alu8_flags_unit dut (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode), .opa(opa), .opb(opb),
        .flag_sel(flag_sel), .result(result), .result_we(result_we), .sreg(sreg)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1:        return "R2";
            2, 3:        return "R3";
            4, 5:        return "R5";
            6, 7, 8:     return "R6";
            9, 10:       return "R8";
            11, 12:      return "R7";
            13, 14, 17:  return "R9";
            15, 16:      return "R10";
            18:          return "R11";
            19, 20:      return "R12";
            default:     return "R14";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // behavioural reference: bits C0 Z1 N2 V3 S4 H5 T6 I7
    task automatic model(input int op, input int a, input int b, input int idx,
                         input logic [7:0] f, output int r, output bit we,
                         output logic [7:0] nf);
        int ci, s, d;
        bit upd_znvs;
        bit v;
        nf = f; r = a; we = 1'b1; upd_znvs = 1'b1; v = 1'b0;
        ci = (op == 1 || op == 3 || op == 5) ? int'(f[0]) : 0;
        case (op)
            0, 1: begin
                s = a + b + ci; r = s & 255;
                nf[0] = (s > 255);
                nf[5] = ((a % 16) + (b % 16) + ci) > 15;
                v = (sx(a) + sx(b) + ci > 127) || (sx(a) + sx(b) + ci < -128);
            end
            2, 3, 4, 5: begin
                d = a - b - ci; r = d & 255;
                nf[0] = (d < 0);
                nf[5] = ((a % 16) - (b % 16) - ci) < 0;
                v = (sx(a) - sx(b) - ci > 127) || (sx(a) - sx(b) - ci < -128);
                we = (op < 4);
            end
            6: r = a & b;
            7: r = a | b;
            8: r = a ^ b;
            9: begin r = 255 - a; nf[0] = 1'b1; end
            10: begin
                r = (256 - a) & 255; nf[0] = (a != 0);
                nf[5] = (a % 16) != 0; v = (a == 128);
            end
            11: begin r = (a + 1) & 255; v = (a == 127); end
            12: begin r = (a + 255) & 255; v = (a == 128); end
            13: begin r = (a * 2) & 255;                nf[0] = (a >= 128); end
            14: begin r = a / 2;                        nf[0] = (a % 2) == 1; end
            15: begin r = ((a * 2) & 255) + int'(f[0]); nf[0] = (a >= 128); end
            16: begin r = a / 2 + 128 * int'(f[0]);     nf[0] = (a % 2) == 1; end
            17: begin r = a / 2 + (a & 128);            nf[0] = (a % 2) == 1; end
            18: begin r = (a % 16) * 16 + a / 16; upd_znvs = 1'b0; end
            19: begin we = 1'b0; upd_znvs = 1'b0; nf[idx] = 1'b1; end
            20: begin we = 1'b0; upd_znvs = 1'b0; nf[idx] = 1'b0; end
            default: begin we = 1'b0; upd_znvs = 1'b0; end
        endcase
        if (op >= 13 && op <= 17) v = (r >= 128) ^ nf[0];
        if (upd_znvs) begin
            nf[2] = (r >= 128);
            nf[3] = v;
            nf[4] = nf[2] ^ v;
            if (op == 3 || op == 5) nf[1] = (r == 0) && f[1];
            else                    nf[1] = (r == 0);
        end
    endtask

    task automatic do_op(input string tag, input int op, input int a, input int b, input int idx);
        int r; bit we; logic [7:0] nf;
        @(negedge clk);
        issue = 1'b1; opcode = 5'(op); opa = 8'(a); opb = 8'(b); flag_sel = 3'(idx);
        #1;
        model(op, a, b, idx, mf, r, we, nf);
        check(tag, "result", int'(result), r);
        check(tag, "result_we", int'(result_we), int'(we));
        @(posedge clk);
        #1;
        issue = 1'b0;
        check(tag, "sreg", int'(sreg), int'(nf));
        if (op <= 17) check("R13", "S=N^V", int'(sreg[4]), int'(sreg[2] ^ sreg[3]));
        mf = nf;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue = 1'b0; opcode = 5'($urandom_range(0, 31)); opa = 8'($urandom); flag_sel = 3'($urandom);
            @(posedge clk);
            #1;
            check("R1", "sreg idle", int'(sreg), int'(mf));
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; issue = 1'b0; opcode = '0; opa = '0; opb = '0; flag_sel = '0;
        mf = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1", "reset sreg", int'(sreg), 0);

        do_op("R2", 0, 8'h0F, 8'h01, 0);
        do_op("R2", 0, 8'h80, 8'h80, 0);
        do_op("R2", 1, 8'hFF, 8'h00, 0);
        do_op("R2", 0, 8'h7F, 8'h01, 0);
        do_op("R3", 2, 8'h10, 8'h01, 0);
        do_op("R3", 3, 8'h00, 8'h00, 0);
        // two-byte compare chains
        do_op("R4", 4, 8'h00, 8'h00, 0);
        do_op("R4", 5, 8'h01, 8'h01, 0);
        check("R4", "Z after equal chain", int'(sreg[1]), 1);
        do_op("R4", 4, 8'h01, 8'h00, 0);
        do_op("R4", 5, 8'h01, 8'h01, 0);
        check("R4", "Z sticky low", int'(sreg[1]), 0);
        do_op("R5", 4, 8'h05, 8'h09, 0);
        do_op("R6", 19, 0, 0, 0);
        do_op("R6", 19, 0, 0, 5);
        do_op("R6", 6, 8'hF0, 8'h0F, 0);
        do_op("R6", 8, 8'hAA, 8'h55, 0);
        do_op("R7", 11, 8'h7F, 0, 0);
        do_op("R7", 12, 8'h80, 0, 0);
        do_op("R8", 9, 8'h00, 0, 0);
        do_op("R8", 10, 8'h80, 0, 0);
        do_op("R8", 10, 8'h00, 0, 0);
        do_op("R9", 14, 8'h01, 0, 0);
        do_op("R9", 17, 8'h81, 0, 0);
        do_op("R9", 13, 8'h80, 0, 0);
        do_op("R10", 19, 0, 0, 0);
        do_op("R10", 15, 8'h40, 0, 0);
        do_op("R10", 16, 8'h02, 0, 0);
        do_op("R10", 16, 8'h01, 0, 0);
        do_op("R10", 15, 8'h00, 0, 0);
        do_op("R11", 18, 8'hA5, 0, 0);
        do_op("R12", 19, 0, 0, 6);
        do_op("R12", 19, 0, 0, 7);
        do_op("R12", 20, 0, 0, 0);
        do_op("R14", 25, 8'h3C, 8'h11, 2);
        do_op("R14", 31, 8'hC3, 8'h22, 1);
        idle(3);

        for (int n = 0; n < 4000; n++) begin
            int op;
            op = $urandom_range(0, 31);
            if ($urandom_range(0, 9) == 0) idle(1);
            do_op(tag_of(op), op, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 7));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule